// File: doc/BRIEF.md
# Audio Sample Buffer with DMA Requests

This block sits between a register interface and the sample streams of an audio codec port. Software or a DMA engine writes 16-bit samples one at a time into a transmit buffer. The block then hands them to a downstream consumer in bursts, and the size of each burst is limited by the free space that the consumer last reported. In the other direction, an upstream producer reports how many samples it holds. The block pulls them in bursts of up to one buffer's depth, and the CPU or DMA reads them back in order.

Two request lines tell the DMA engine when each side can be serviced. Each line is gated by its own enable bit. Two status flags mirror the same conditions for a control register. A configuration-change pulse drains whatever transmit data fits in the advertised space and then clears every count on both sides.

Top module: `snd_sample_buf`

## Requirements
- R1: After reset both request lines, both status flags, `snk_valid_o` and `src_ready_o` are low, and `dr_data_o` reads zero.
- R2: A write on `dw_wr_i` appends one sample. While no burst is in flight, `tx_drq_o` is high exactly when `tx_dma_en_i` is high and the buffered count is below the advertised free space.
- R3: When a write brings the buffered count equal to a nonzero advertised free space, or to the depth, a burst starts on the next cycle. The buffered words leave in write order, one per cycle in which `snk_ready_i` is high. The word is held while ready is low. The free space is reduced by the burst length.
- R4: If a write fills the buffer while the advertised free space is zero, the buffered words are discarded and no burst starts.
- R5: A free-space report below the buffered count cuts the count to the reported value, and only that many of the oldest words are sent.
- R6: A free-space report that leaves a nonzero buffered count starts a burst of that count.
- R7: When a write and a free-space report arrive in the same cycle, the write is counted first and the cut is applied to the total.
- R8: While a transmit burst is in flight, writes and free-space reports are ignored and `tx_drq_o` is low.
- R9: `rx_drq_o` is high exactly when `rx_dma_en_i` is high, no refill is in flight, and samples are either buffered or reported as available. While the buffer is empty and samples are available, a refill of the smaller of the available count and the depth is taken from the producer, one word per accepted handshake.
- R10: Reads on `dr_rd_i` return the buffered samples in arrival order. A read with nothing buffered returns zero and changes nothing.
- R11: After the last buffered word is read, a further refill follows if the producer still reports samples. Otherwise the request and `st_rx_any_o` drop.
- R12: A pulse on `cfg_chg_i` sends the buffered transmit words that fit in the advertised space. After that, or at once if none fit, every count on both sides is cleared and any refill is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dma_en_i | input | 1 | Transmit request enable |
| rx_dma_en_i | input | 1 | Receive request enable |
| cfg_chg_i | input | 1 | Configuration changed: flush and clear |
| dw_wr_i | input | 1 | Write strobe of the data-write register |
| dw_data_i | input | DW | Sample written |
| dr_rd_i | input | 1 | Read strobe of the data-read register |
| dr_data_o | output | DW | Sample returned by the current read |
| tx_upd_i | input | 1 | Consumer free-space report strobe |
| tx_free_i | input | AV_W | Reported free slots |
| snk_valid_o | output | 1 | Burst word valid toward the consumer |
| snk_data_o | output | DW | Burst word |
| snk_ready_i | input | 1 | Consumer accepts the word |
| rx_upd_i | input | 1 | Producer availability report strobe |
| rx_avail_i | input | AV_W | Reported available samples |
| src_valid_i | input | 1 | Producer word valid |
| src_data_i | input | DW | Producer word |
| src_ready_o | output | 1 | Refill in flight, word accepted |
| tx_drq_o | output | 1 | Transmit DMA request |
| rx_drq_o | output | 1 | Receive DMA request |
| st_rx_any_o | output | 1 | Receive data buffered, in flight or available |
| st_tx_room_o | output | 1 | Buffered transmit count below free space |

## Verification
A sample write and a free-space report can fall in the same cycle. In that case the write must be counted before the count is cut to the new space. The bench provokes this by raising both strobes on one edge, once with the space below the total and once above it. It judges the result by the exact words that leave and by the state of the transmit request after the burst. A second pair is a flush that arrives while a refill is half done. There the bench checks that the transmit words still leave before the receive side is cleared.

// File: rtl/snd_buf_pkg.sv
package snd_buf_pkg;
  function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/snd_tx_stage.sv
module snd_tx_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int AV_W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          upd_i,
  input  logic [AV_W-1:0] free_i,
  output logic          snk_valid_o,
  output logic [DW-1:0] snk_data_o,
  input  logic          snk_ready_i,
  output logic          drq_o,
  output logic          room_o,
  output logic          go_o,
  output logic          disc_o,
  output logic          clr_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cnt, dlen, cnt_w, cnt_c, fl_len;
  logic [IDX_W-1:0] idx;
  logic [AV_W-1:0]  avail, av_n;
  logic             draining, fl_pend, idle, hit, last;

  function automatic logic [CNT_W-1:0] cap(input logic [CNT_W-1:0] c, input logic [AV_W-1:0] a);
    return CNT_W'(snd_buf_pkg::umin(32'(c), 32'(a)));
  endfunction

  always_comb begin
    idle   = !draining;
    cnt_w  = cnt + CNT_W'(wr_i);
    cnt_c  = upd_i ? cap(cnt_w, free_i) : cnt_w;
    av_n   = upd_i ? free_i : avail;
    fl_len = cap(cnt, avail);
    hit    = wr_i && (cnt_w == CNT_W'(DEPTH) || AV_W'(cnt_w) == avail);
    go_o   = idle && !flush_i && (upd_i ? (cnt_c != '0) : (hit && avail != '0));
    disc_o = idle && !flush_i && !upd_i && hit && avail == '0;
    last   = draining && snk_ready_i && (CNT_W'(idx) == dlen - CNT_W'(1));
    clr_o  = (idle && flush_i && fl_len == '0) || (last && (fl_pend || flush_i));
  end

  always_ff @(posedge clk) begin
    if (idle && !flush_i && wr_i) mem[cnt[IDX_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; avail <= '0; dlen <= '0; idx <= '0;
      draining <= 1'b0; fl_pend <= 1'b0;
    end else if (idle) begin
      if (flush_i) begin
        if (fl_len != '0) begin
          draining <= 1'b1; dlen <= fl_len; idx <= '0; fl_pend <= 1'b1;
        end else begin
          cnt <= '0; avail <= '0;
        end
      end else begin
        cnt   <= disc_o ? '0 : cnt_c;
        avail <= av_n;
        if (go_o) begin
          draining <= 1'b1; dlen <= cnt_c; idx <= '0;
        end
      end
    end else begin
      if (flush_i) fl_pend <= 1'b1;
      if (snk_ready_i) begin
        idx <= idx + IDX_W'(1);
        if (last) begin
          draining <= 1'b0;
          cnt      <= '0;
          fl_pend  <= 1'b0;
          avail    <= (fl_pend || flush_i) ? '0 : avail - AV_W'(dlen);
        end
      end
    end
  end

  assign snk_valid_o = draining;
  assign snk_data_o  = mem[idx];
  assign room_o      = AV_W'(cnt) < avail;
  assign drq_o       = en_i && idle && room_o;
endmodule

// File: rtl/snd_rx_stage.sv
module snd_rx_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int AV_W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [AV_W-1:0] avail_i,
  input  logic          src_valid_i,
  input  logic [DW-1:0] src_data_i,
  output logic          src_ready_o,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          drq_o,
  output logic          any_o,
  output logic          start_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] len, ftgt, batch;
  logic [IDX_W-1:0] ridx, fidx;
  logic [AV_W-1:0]  pend;
  logic             filling, acc, fin, rd_ok;

  function automatic logic [CNT_W-1:0] burst(input logic [AV_W-1:0] p);
    return CNT_W'(snd_buf_pkg::umin(32'(p), 32'(DEPTH)));
  endfunction

  always_comb begin
    batch   = burst(pend);
    start_o = !clr_i && !filling && len == '0 && pend != '0 && !upd_i;
    acc     = filling && src_valid_i;
    fin     = acc && (CNT_W'(fidx) == ftgt - CNT_W'(1));
    rd_ok   = rd_i && len != '0;
  end

  always_ff @(posedge clk) begin
    if (acc) mem[fidx] <= src_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0; ridx <= '0; pend <= '0; filling <= 1'b0; fidx <= '0; ftgt <= '0;
    end else if (clr_i) begin
      len <= '0; ridx <= '0; pend <= '0; filling <= 1'b0; fidx <= '0;
    end else begin
      if (upd_i) pend <= avail_i;
      else if (start_o) pend <= pend - AV_W'(batch);
      if (start_o) begin
        filling <= 1'b1; fidx <= '0; ftgt <= batch;
      end
      if (acc) begin
        fidx <= fidx + IDX_W'(1);
        if (fin) begin
          filling <= 1'b0; len <= ftgt; ridx <= '0;
        end
      end
      if (rd_ok) begin
        ridx <= ridx + IDX_W'(1);
        len  <= len - CNT_W'(1);
      end
    end
  end

  assign rd_data_o   = (len != '0) ? mem[ridx] : '0;
  assign src_ready_o = filling;
  assign any_o       = len != '0 || pend != '0 || filling;
  assign drq_o       = en_i && !filling && (len != '0 || pend != '0);
endmodule

// File: rtl/snd_sample_buf.sv
module snd_sample_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int AV_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_dma_en_i,
  input  logic            rx_dma_en_i,
  input  logic            cfg_chg_i,
  input  logic            dw_wr_i,
  input  logic [DW-1:0]   dw_data_i,
  input  logic            dr_rd_i,
  output logic [DW-1:0]   dr_data_o,
  input  logic            tx_upd_i,
  input  logic [AV_W-1:0] tx_free_i,
  output logic            snk_valid_o,
  output logic [DW-1:0]   snk_data_o,
  input  logic            snk_ready_i,
  input  logic            rx_upd_i,
  input  logic [AV_W-1:0] rx_avail_i,
  input  logic            src_valid_i,
  input  logic [DW-1:0]   src_data_i,
  output logic            src_ready_o,
  output logic            tx_drq_o,
  output logic            rx_drq_o,
  output logic            st_rx_any_o,
  output logic            st_tx_room_o
);
  logic tx_go, tx_disc, tx_clr, rx_start;

  snd_tx_stage #(.DW(DW), .DEPTH(DEPTH), .AV_W(AV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(tx_dma_en_i), .flush_i(cfg_chg_i),
    .wr_i(dw_wr_i), .wr_data_i(dw_data_i), .upd_i(tx_upd_i), .free_i(tx_free_i),
    .snk_valid_o(snk_valid_o), .snk_data_o(snk_data_o), .snk_ready_i(snk_ready_i),
    .drq_o(tx_drq_o), .room_o(st_tx_room_o), .go_o(tx_go), .disc_o(tx_disc), .clr_o(tx_clr)
  );

  snd_rx_stage #(.DW(DW), .DEPTH(DEPTH), .AV_W(AV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(rx_dma_en_i), .clr_i(tx_clr),
    .upd_i(rx_upd_i), .avail_i(rx_avail_i), .src_valid_i(src_valid_i),
    .src_data_i(src_data_i), .src_ready_o(src_ready_o), .rd_i(dr_rd_i),
    .rd_data_o(dr_data_o), .drq_o(rx_drq_o), .any_o(st_rx_any_o), .start_o(rx_start)
  );
endmodule

// File: rtl/snd_buf_chk.sv
module snd_buf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_dma_en_i,
  input logic          rx_dma_en_i,
  input logic          snk_valid_o,
  input logic [DW-1:0] snk_data_o,
  input logic          snk_ready_i,
  input logic          src_ready_o,
  input logic          tx_drq_o,
  input logic          rx_drq_o,
  input logic          st_rx_any_o,
  input logic          st_tx_room_o,
  input logic [DW-1:0] dr_data_o,
  input logic          tx_disc,
  input logic          tx_clr,
  input logic          rx_start
);
  p_txen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drq_o |-> tx_dma_en_i && st_tx_room_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid_o && !snk_ready_i |=> snk_valid_o && $stable(snk_data_o));
  p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disc |=> !snk_valid_o);
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid_o |-> !tx_drq_o);
  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> !rx_drq_o);
  p_rxen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en_i |-> !rx_drq_o);
  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> src_ready_o);
  p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rx_any_o |-> dr_data_o == '0);
  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> !tx_drq_o && !rx_drq_o && !src_ready_o && !st_rx_any_o);
endmodule

bind snd_sample_buf snd_buf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_dma_en_i(tx_dma_en_i), .rx_dma_en_i(rx_dma_en_i),
  .snk_valid_o(snk_valid_o), .snk_data_o(snk_data_o), .snk_ready_i(snk_ready_i),
  .src_ready_o(src_ready_o), .tx_drq_o(tx_drq_o), .rx_drq_o(rx_drq_o),
  .st_rx_any_o(st_rx_any_o), .st_tx_room_o(st_tx_room_o), .dr_data_o(dr_data_o),
  .tx_disc(tx_disc), .tx_clr(tx_clr), .rx_start(rx_start)
);

// File: tb/snd_sample_buf_tb.sv
`timescale 1ns/100ps
module snd_sample_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1, cfg = 1'b0;
  logic dw_wr = 1'b0, dr_rd = 1'b0, tx_upd = 1'b0, rx_upd = 1'b0;
  logic snk_ready = 1'b1, src_valid = 1'b0;
  logic [15:0] dw_data = '0, src_data = '0, dr_data, snk_data;
  logic [15:0] tx_free = '0, rx_avail = '0;
  logic snk_valid, src_ready, tx_drq, rx_drq, st_rx, st_tx;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snd_sample_buf u_dut (
    .clk(clk), .rst_n(rst_n), .tx_dma_en_i(tx_en), .rx_dma_en_i(rx_en), .cfg_chg_i(cfg),
    .dw_wr_i(dw_wr), .dw_data_i(dw_data), .dr_rd_i(dr_rd), .dr_data_o(dr_data),
    .tx_upd_i(tx_upd), .tx_free_i(tx_free), .snk_valid_o(snk_valid), .snk_data_o(snk_data),
    .snk_ready_i(snk_ready), .rx_upd_i(rx_upd), .rx_avail_i(rx_avail),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .tx_drq_o(tx_drq), .rx_drq_o(rx_drq), .st_rx_any_o(st_rx), .st_tx_room_o(st_tx)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    dw_wr = 1'b1; dw_data = d; cyc(); dw_wr = 1'b0;
  endtask

  task automatic report_free(input logic [15:0] v);
    tx_upd = 1'b1; tx_free = v; cyc(); tx_upd = 1'b0;
  endtask

  task automatic report_rx(input logic [15:0] v);
    rx_upd = 1'b1; rx_avail = v; cyc(); rx_upd = 1'b0;
  endtask

  task automatic take(input int n, input logic [15:0] base, input string tag);
    snk_ready = 1'b1;
    for (int k = 0; k < n; k++) begin
      chk(snk_valid && snk_data == 16'(base + k), tag, {snk_valid, snk_data}, {1'b1, 16'(base + k)});
      cyc();
    end
    chk(!snk_valid, {tag, " burst end"}, snk_valid, 0);
  endtask

  task automatic feed(input int n, input logic [15:0] base);
    for (int k = 0; k < n; k++) begin
      src_valid = 1'b1; src_data = 16'(base + k);
      while (!src_ready) cyc();
      cyc();
    end
    src_valid = 1'b0;
  endtask

  task automatic pull(input int n, input logic [15:0] base, input string tag);
    for (int k = 0; k < n; k++) begin
      dr_rd = 1'b1; #0.1;
      chk(dr_data == 16'(base + k), tag, dr_data, 16'(base + k));
      cyc();
    end
    dr_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk(!tx_drq && !rx_drq, "R1 requests", {tx_drq, rx_drq}, 0);
    chk(!snk_valid && !src_ready, "R1 handshakes", {snk_valid, src_ready}, 0);
    chk(dr_data == 0 && !st_rx && !st_tx, "R1 data/status", {dr_data, st_rx, st_tx}, 0);
  endtask

  task automatic t_txreq();
    report_free(4);
    chk(tx_drq, "R2 request with room", tx_drq, 1);
    tx_en = 1'b0; #0.1;
    chk(!tx_drq, "R2 request gated", tx_drq, 0);
    tx_en = 1'b1;
  endtask

  task automatic t_drain();
    push(16'h100); push(16'h101); push(16'h102);
    chk(tx_drq && !snk_valid, "R2 below space", {tx_drq, snk_valid}, 2'b10);
    snk_ready = 1'b0;
    push(16'h103);
    chk(snk_valid && snk_data == 16'h100, "R3 burst start", snk_data, 16'h100);
    cyc();
    chk(snk_valid && snk_data == 16'h100, "R3 stall hold", snk_data, 16'h100);
    take(4, 16'h100, "R3 burst order");
    chk(!tx_drq && !st_tx, "R3 space consumed", {tx_drq, st_tx}, 0);
  endtask

  task automatic t_discard();
    for (int k = 0; k < 1024; k++) push(16'(k));
    chk(!snk_valid, "R4 no burst on full", snk_valid, 0);
    report_free(3);
    chk(!snk_valid && tx_drq, "R4 buffer emptied", {snk_valid, tx_drq}, 2'b01);
    push(16'h500); push(16'h501); push(16'h502);
    take(3, 16'h500, "R4 fresh data only");
  endtask

  task automatic t_capped();
    report_free(10);
    for (int k = 0; k < 5; k++) push(16'(16'h200 + k));
    chk(!snk_valid && tx_drq, "R5 waiting", {snk_valid, tx_drq}, 2'b01);
    report_free(3);
    take(3, 16'h200, "R5 cut burst");
    chk(!tx_drq, "R6 space used", tx_drq, 0);
  endtask

  task automatic t_same();
    report_free(6);
    push(16'h300); push(16'h301);
    dw_wr = 1'b1; dw_data = 16'h302; tx_upd = 1'b1; tx_free = 2; cyc();
    dw_wr = 1'b0; tx_upd = 1'b0;
    take(2, 16'h300, "R7 cut after write");
    chk(!tx_drq, "R7 space left", tx_drq, 0);
    report_free(6);
    push(16'h310);
    dw_wr = 1'b1; dw_data = 16'h311; tx_upd = 1'b1; tx_free = 5; cyc();
    dw_wr = 1'b0; tx_upd = 1'b0;
    take(2, 16'h310, "R7 write counted");
    chk(tx_drq, "R7 remaining space", tx_drq, 1);
    report_free(0);
  endtask

  task automatic t_ignore();
    report_free(3);
    snk_ready = 1'b0;
    push(16'h400); push(16'h401); push(16'h402);
    dw_wr = 1'b1; dw_data = 16'h4ff; tx_upd = 1'b1; tx_free = 100; cyc();
    dw_wr = 1'b0; tx_upd = 1'b0;
    chk(!tx_drq, "R8 no request in burst", tx_drq, 0);
    take(3, 16'h400, "R8 burst intact");
    chk(!tx_drq, "R8 report ignored", tx_drq, 0);
    report_free(1);
    push(16'h410);
    take(1, 16'h410, "R8 write ignored");
  endtask

  task automatic t_rx();
    chk(!rx_drq, "R9 idle request", rx_drq, 0);
    dr_rd = 1'b1; #0.1;
    chk(dr_data == 0, "R10 empty read", dr_data, 0);
    cyc(); dr_rd = 1'b0;
    chk(!st_rx, "R10 empty read no effect", st_rx, 0);
    report_rx(3);
    chk(rx_drq && !src_ready, "R9 available", {rx_drq, src_ready}, 2'b10);
    cyc();
    chk(src_ready && !rx_drq, "R9 refill busy", {src_ready, rx_drq}, 2'b10);
    feed(3, 16'h700);
    chk(rx_drq && !src_ready, "R9 refilled", {rx_drq, src_ready}, 2'b10);
    rx_en = 1'b0; #0.1;
    chk(!rx_drq, "R9 gated", rx_drq, 0);
    rx_en = 1'b1;
    pull(3, 16'h700, "R10 read order");
    chk(!rx_drq && !st_rx && dr_data == 0, "R11 drained", {rx_drq, st_rx, dr_data}, 0);
  endtask

  task automatic t_refill();
    report_rx(1030);
    cyc();
    feed(1024, 16'h0);
    pull(1024, 16'h0, "R9 full batch");
    chk(rx_drq && !src_ready, "R11 more pending", {rx_drq, src_ready}, 2'b10);
    cyc();
    chk(src_ready, "R11 second refill", src_ready, 1);
    feed(6, 16'h800);
    pull(6, 16'h800, "R11 second batch");
    chk(!rx_drq && !st_rx, "R11 all read", {rx_drq, st_rx}, 0);
  endtask

  task automatic t_flush();
    report_free(10);
    push(16'h600); push(16'h601);
    report_rx(5);
    cyc();
    feed(2, 16'h900);
    chk(src_ready, "R12 refill midway", src_ready, 1);
    cfg = 1'b1; cyc(); cfg = 1'b0;
    take(2, 16'h600, "R12 flush burst");
    chk(!tx_drq && !st_tx, "R12 tx cleared", {tx_drq, st_tx}, 0);
    chk(!rx_drq && !src_ready && !st_rx && dr_data == 0, "R12 rx cleared",
        {rx_drq, src_ready, st_rx}, 0);
    report_free(4);
    cfg = 1'b1; cyc(); cfg = 1'b0;
    chk(!tx_drq && !snk_valid, "R12 empty flush", {tx_drq, snk_valid}, 0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_txreq();
    t_drain();
    t_discard();
    t_capped();
    t_same();
    t_ignore();
    t_rx();
    t_refill();
    t_flush();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule